// File: doc/BRIEF.md
# Cylinder/Head/Sector Transfer Sequencer

This block runs multi-sector transfers on a disk addressed by cylinder, head and sector. A host writes a command block one byte at a time; the block gathers it, unpacks the starting position, sector count and control byte, and then walks through the requested sectors. For each sector it works out a linear block address from the drive's geometry and moves 512 data beats through a byte handshake. The handshake is either host strobes (programmed I/O) or a DMA request/acknowledge pair, chosen per drive by the control byte.

Reads raise a sector-start strobe carrying the linear address before the first byte of each sector, so a storage back end can fetch it. Writes raise a sector-commit strobe carrying the address after the last byte of each sector. Between sectors the position steps through sector, head and cylinder in that order. A set-parameters command loads the drive's geometry. Each of the two drives keeps its own geometry, position and control registers. The data bytes themselves, ECC and head movement are handled elsewhere. The beat index output tells the data path where each byte goes.

Top module: `chs_seq`

## Requirements
- R1: After reset `busy`, `done`, `dma_req`, `sec_start` and `sec_commit` are low, and both drives hold the default geometry: 612 cylinders, 4 heads, reduced-current start 613, precompensation start 613, ECC length 11.
- R2: The opcode is byte 0: 0x08 reads, 0x0A writes, 0x0C sets parameters. Byte 1 bit 5 selects the drive and bits 4:0 give the head. Byte 2 bits 7:6 are cylinder bits 9:8 and bits 5:0 the sector. Byte 3 is cylinder bits 7:0, byte 4 the sector count and byte 5 the control byte.
- R3: `lba` equals ((cylinder × heads) + head) × 17 + sector, using the active drive's head count and current position.
- R4: A read raises `sec_start` for one cycle before each sector, with `lba` and the `cur_*` outputs showing that sector and `byte_idx` at 0.
- R5: A write raises `sec_commit` for one cycle after the 512th beat of each sector, with `lba` and `cur_*` showing that sector.
- R6: After each sector the sector number steps by one. When it reaches 17 it wraps to 0 and the head steps. When the head reaches the head count it wraps to 0 and the cylinder steps.
- R7: If control bits 1:0 are nonzero, beats are taken only on `dma_ack` while `dma_req` is high, and `pio_stb` has no effect. Otherwise `dma_req` stays low and each `pio_stb` cycle is a beat.
- R8: Set-parameters bytes 6 to 13 load the selected drive's cylinders ({byte6[1:0], byte7}), heads (byte8[4:0]), reduced-current start ({byte9[1:0], byte10}), precompensation start ({byte11[1:0], byte12}) and ECC length (byte13).
- R9: `done` is high for exactly one cycle after the final beat of the final sector, or after a set-parameters command. A sector count of 0 gives `done` within three cycles with no strobes.
- R10: Geometry, position and control are held per drive. Loading one drive leaves the other drive's values unchanged.
- R11: Control bit 7 appears on `ctl_no_retry`, bit 6 on `ctl_no_ecc_retry` and bits 2:0 on `ctl_step` for the active drive.
- R12: A first byte that is not a known opcode is dropped. Command bytes written while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| pio_stb | input | 1 | Programmed I/O beat strobe |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| busy | output | 1 | Command executing |
| done | output | 1 | One-cycle completion pulse |
| sec_start | output | 1 | Read sector fetch strobe |
| sec_commit | output | 1 | Write sector commit strobe |
| lba | output | LBA_W | Linear block address of the current sector |
| cur_drive | output | 1 | Active drive |
| cur_cyl | output | 10 | Current cylinder |
| cur_head | output | 5 | Current head |
| cur_sec | output | 6 | Current sector |
| byte_idx | output | log2(SECTOR_BYTES) | Beat index within the sector |
| geo_cyls | output | 10 | Active drive cylinder count |
| geo_heads | output | 5 | Active drive head count |
| geo_rwc | output | 10 | Active drive reduced-current start cylinder |
| geo_wpc | output | 10 | Active drive precompensation start cylinder |
| geo_ecc | output | 8 | Active drive ECC length |
| ctl_no_retry | output | 1 | Retry-disable flag |
| ctl_no_ecc_retry | output | 1 | ECC-retry-disable flag |
| ctl_step | output | 3 | Step rate |

## Verification
The sequencer is driven with a read that starts two sectors before a track end, which separates a correct sector-to-head carry from a missing one. It also gets a DMA write that starts on the last sector of the last head, which tests the carry into the cylinder and the split cylinder field. A read on the second drive after it has been loaded with six heads shows whether the address and the head wrap use that drive's own geometry. A later zero-count command on the first drive then shows that the defaults were kept. Stalls with host strobes held against a DMA drive, a stray opcode, and a byte written mid-transfer check that ignored input leaves both the beat index and the parsing of the next command untouched.

// File: rtl/chs_pkg.sv
package chs_pkg;

    localparam int NUM_DRIVES = 2;
    localparam int CMD_BYTES  = 6;
    localparam int FULL_BYTES = 14;

    localparam logic [7:0] OP_READ  = 8'h08;
    localparam logic [7:0] OP_WRITE = 8'h0A;
    localparam logic [7:0] OP_SETP  = 8'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_XFER,
        ST_COMMIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [9:0] cyl;
        logic [4:0] head;
        logic [5:0] sec;
    } chs_pos_t;

    typedef struct packed {
        logic [9:0] cyls;
        logic [4:0] heads;
        logic [9:0] rwc;
        logic [9:0] wpc;
        logic [7:0] ecc;
    } geom_t;

    localparam geom_t GEO_DEFAULT = '{
        cyls:  10'd612,
        heads: 5'd4,
        rwc:   10'd613,
        wpc:   10'd613,
        ecc:   8'd11
    };

endpackage

// File: rtl/chs_cmd_collect.sv
module chs_cmd_collect
    import chs_pkg::*;
#(
    parameter int MAX_BYTES = FULL_BYTES
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           accept,
    input  logic                           we,
    input  logic [7:0]                     wdata,
    output logic                           blk_valid,
    output logic [MAX_BYTES-1:0][7:0]      blk
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            need;
        logic [MAX_BYTES-1:0][7:0]   bytes;
        logic                        valid;
    } col_t;

    col_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (accept && we) begin
            if (q.cnt == '0) begin
                case (wdata)
                    OP_READ, OP_WRITE: d.need = CNT_W'(CMD_BYTES);
                    OP_SETP:           d.need = CNT_W'(FULL_BYTES);
                    default:           d.need = '0;
                endcase
                if (d.need != '0) begin
                    d.bytes[0] = wdata;
                    d.cnt      = CNT_W'(1);
                end
            end else begin
                d.bytes[q.cnt] = wdata;
                if (q.cnt == q.need - CNT_W'(1)) begin
                    d.cnt   = '0;
                    d.valid = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign blk_valid = q.valid;
    assign blk       = q.bytes;

endmodule

// File: rtl/chs_lba.sv
module chs_lba #(
    parameter int LBA_W = 24,
    parameter int SPT   = 17
) (
    input  logic [9:0]       cyl,
    input  logic [4:0]       head,
    input  logic [5:0]       sec,
    input  logic [4:0]       heads,
    output logic [LBA_W-1:0] lba
);
    logic [LBA_W-1:0] track;

    always_comb begin
        track = LBA_W'(cyl) * LBA_W'(heads) + LBA_W'(head);
        lba   = track * LBA_W'(SPT) + LBA_W'(sec);
    end

endmodule

// File: rtl/chs_step.sv
module chs_step
    import chs_pkg::*;
#(
    parameter int SPT = 17
) (
    input  chs_pos_t   cur,
    input  logic [4:0] heads,
    output chs_pos_t   nxt
);
    logic [6:0] sec_inc;
    logic [5:0] head_inc;

    always_comb begin
        nxt      = cur;
        sec_inc  = {1'b0, cur.sec} + 7'd1;
        head_inc = {1'b0, cur.head} + 6'd1;
        if (sec_inc >= 7'(SPT)) begin
            nxt.sec = '0;
            if (head_inc >= {1'b0, heads}) begin
                nxt.head = '0;
                nxt.cyl  = cur.cyl + 10'd1;
            end else begin
                nxt.head = head_inc[4:0];
            end
        end else begin
            nxt.sec = sec_inc[5:0];
        end
    end

endmodule

// File: rtl/chs_seq.sv
module chs_seq
    import chs_pkg::*;
#(
    parameter int SPT          = 17,
    parameter int SECTOR_BYTES = 512,
    parameter int LBA_W        = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_we,
    input  logic [7:0]                      cmd_data,
    input  logic                            pio_stb,
    input  logic                            dma_ack,
    output logic                            dma_req,
    output logic                            busy,
    output logic                            done,
    output logic                            sec_start,
    output logic                            sec_commit,
    output logic [LBA_W-1:0]                lba,
    output logic                            cur_drive,
    output logic [9:0]                      cur_cyl,
    output logic [4:0]                      cur_head,
    output logic [5:0]                      cur_sec,
    output logic [$clog2(SECTOR_BYTES)-1:0] byte_idx,
    output logic [9:0]                      geo_cyls,
    output logic [4:0]                      geo_heads,
    output logic [9:0]                      geo_rwc,
    output logic [9:0]                      geo_wpc,
    output logic [7:0]                      geo_ecc,
    output logic                            ctl_no_retry,
    output logic                            ctl_no_ecc_retry,
    output logic [2:0]                      ctl_step
);
    localparam int BIDX_W = $clog2(SECTOR_BYTES);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(SECTOR_BYTES - 1);

    typedef struct packed {
        seq_state_e                       state;
        logic                             drv;
        logic                             is_wr;
        logic [7:0]                       remain;
        logic [BIDX_W-1:0]                bidx;
        chs_pos_t [NUM_DRIVES-1:0]        pos;
        geom_t    [NUM_DRIVES-1:0]        geo;
        logic     [NUM_DRIVES-1:0][7:0]   ctrl;
    } seq_t;

    seq_t q, d;

    logic                        blk_valid;
    logic [FULL_BYTES-1:0][7:0]  blk;
    logic                        cmd_drv;
    chs_pos_t                    cmd_pos;
    geom_t                       cmd_geo;
    chs_pos_t                    act_pos;
    chs_pos_t                    nxt_pos;
    geom_t                       act_geo;
    logic [7:0]                  act_ctrl;
    logic                        dma_mode;
    logic                        beat;

    chs_cmd_collect #(.MAX_BYTES(FULL_BYTES)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (q.state == ST_IDLE),
        .we        (cmd_we),
        .wdata     (cmd_data),
        .blk_valid (blk_valid),
        .blk       (blk)
    );

    // Field unpacking of the command block
    assign cmd_drv      = blk[1][5];
    assign cmd_pos.head = blk[1][4:0];
    assign cmd_pos.sec  = blk[2][5:0];
    assign cmd_pos.cyl  = {blk[2][7:6], blk[3]};
    assign cmd_geo.cyls  = {blk[6][1:0], blk[7]};
    assign cmd_geo.heads = blk[8][4:0];
    assign cmd_geo.rwc   = {blk[9][1:0], blk[10]};
    assign cmd_geo.wpc   = {blk[11][1:0], blk[12]};
    assign cmd_geo.ecc   = blk[13];

    assign act_pos  = q.pos[q.drv];
    assign act_geo  = q.geo[q.drv];
    assign act_ctrl = q.ctrl[q.drv];
    assign dma_mode = act_ctrl[1:0] != 2'b00;

    chs_step #(.SPT(SPT)) u_step (
        .cur   (act_pos),
        .heads (act_geo.heads),
        .nxt   (nxt_pos)
    );

    chs_lba #(.LBA_W(LBA_W), .SPT(SPT)) u_lba (
        .cyl   (act_pos.cyl),
        .head  (act_pos.head),
        .sec   (act_pos.sec),
        .heads (act_geo.heads),
        .lba   (lba)
    );

    always_comb begin
        d    = q;
        beat = (q.state == ST_XFER) && (dma_mode ? dma_ack : pio_stb);
        case (q.state)
            ST_IDLE: begin
                if (blk_valid) begin
                    d.drv            = cmd_drv;
                    d.pos[cmd_drv]   = cmd_pos;
                    d.ctrl[cmd_drv]  = blk[5];
                    d.remain         = blk[4];
                    d.bidx           = '0;
                    d.is_wr          = (blk[0] == OP_WRITE);
                    if (blk[0] == OP_SETP) begin
                        d.geo[cmd_drv] = cmd_geo;
                        d.state        = ST_DONE;
                    end else if (blk[4] == 8'd0) begin
                        d.state = ST_DONE;
                    end else if (blk[0] == OP_WRITE) begin
                        d.state = ST_XFER;
                    end else begin
                        d.state = ST_START;
                    end
                end
            end
            ST_START: d.state = ST_XFER;
            ST_XFER: begin
                if (beat) begin
                    if (q.bidx == LAST_IDX) begin
                        d.bidx = '0;
                        if (q.is_wr) begin
                            d.state = ST_COMMIT;
                        end else begin
                            d.pos[q.drv] = nxt_pos;
                            d.remain     = q.remain - 8'd1;
                            d.state      = (q.remain == 8'd1) ? ST_DONE : ST_START;
                        end
                    end else begin
                        d.bidx = q.bidx + BIDX_W'(1);
                    end
                end
            end
            ST_COMMIT: begin
                d.pos[q.drv] = nxt_pos;
                d.remain     = q.remain - 8'd1;
                d.state      = (q.remain == 8'd1) ? ST_DONE : ST_XFER;
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < NUM_DRIVES; i++) begin
                q.geo[i] <= GEO_DEFAULT;
            end
        end else begin
            q <= d;
        end
    end

    assign busy             = q.state != ST_IDLE;
    assign done             = q.state == ST_DONE;
    assign sec_start        = q.state == ST_START;
    assign sec_commit       = q.state == ST_COMMIT;
    assign dma_req          = (q.state == ST_XFER) && dma_mode;
    assign cur_drive        = q.drv;
    assign cur_cyl          = act_pos.cyl;
    assign cur_head         = act_pos.head;
    assign cur_sec          = act_pos.sec;
    assign byte_idx         = q.bidx;
    assign geo_cyls         = act_geo.cyls;
    assign geo_heads        = act_geo.heads;
    assign geo_rwc          = act_geo.rwc;
    assign geo_wpc          = act_geo.wpc;
    assign geo_ecc          = act_geo.ecc;
    assign ctl_no_retry     = act_ctrl[7];
    assign ctl_no_ecc_retry = act_ctrl[6];
    assign ctl_step         = act_ctrl[2:0];

endmodule

// File: rtl/chs_seq_chk.sv
module chs_seq_chk #(
    parameter int BW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          dma_req,
    input logic          sec_start,
    input logic          sec_commit,
    input logic [BW-1:0] byte_idx
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_start |-> (byte_idx == '0)); // R4

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_start |=> !sec_start); // R4

    AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sec_commit |-> ($past(byte_idx) == '1)); // R5

    AST_NO_DMA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dma_req); // R7

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_start && sec_commit)); // R5

endmodule

bind chs_seq chs_seq_chk #(.BW(BIDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .dma_req    (dma_req),
    .sec_start  (sec_start),
    .sec_commit (sec_commit),
    .byte_idx   (byte_idx)
);

// File: tb/sim_chs_seq.sv
module sim_chs_seq;
    localparam int SPT = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        pio_stb = 1'b0;
    logic        dma_ack = 1'b0;
    logic        dma_req, busy, done, sec_start, sec_commit, cur_drive;
    logic [23:0] lba;
    logic [9:0]  cur_cyl, geo_cyls, geo_rwc, geo_wpc;
    logic [4:0]  cur_head, geo_heads;
    logic [5:0]  cur_sec;
    logic [8:0]  byte_idx;
    logic [7:0]  geo_ecc;
    logic        ctl_no_retry, ctl_no_ecc_retry;
    logic [2:0]  ctl_step;

    always #2 clk = ~clk;

    chs_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .pio_stb(pio_stb), .dma_ack(dma_ack), .dma_req(dma_req), .busy(busy),
        .done(done), .sec_start(sec_start), .sec_commit(sec_commit), .lba(lba),
        .cur_drive(cur_drive), .cur_cyl(cur_cyl), .cur_head(cur_head),
        .cur_sec(cur_sec), .byte_idx(byte_idx), .geo_cyls(geo_cyls),
        .geo_heads(geo_heads), .geo_rwc(geo_rwc), .geo_wpc(geo_wpc),
        .geo_ecc(geo_ecc), .ctl_no_retry(ctl_no_retry),
        .ctl_no_ecc_retry(ctl_no_ecc_retry), .ctl_step(ctl_step)
    );

    typedef struct {
        bit commit;
        int lba;
        int cyl;
        int head;
        int sec;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;
    int   errs = 0;
    int   checks = 0;
    bit   finished = 0;
    int   heads_m[2];
    bit   pump_en = 0;
    bit   dma_tb = 0;
    bit   force_pio = 0;
    int   fc, fh, fs;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int lba_of(input int c, input int h, input int s, input int hd);
        return (c * hd + h) * SPT + s;
    endfunction

    // Beat driver
    always @(negedge clk) begin
        pio_stb = force_pio || (pump_en && !dma_tb);
        dma_ack = pump_en && dma_tb && dma_req;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished && (sec_start || sec_commit)) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4/R5 unexpected strobe", int'(lba), -1);
            end else begin
                mon_e = expq.pop_front();
                chk(sec_commit == mon_e.commit, mon_e.commit ? "R5 strobe kind" : "R4 strobe kind",
                    int'(sec_commit), int'(mon_e.commit));
                chk(int'(lba) == mon_e.lba, "R3 lba", int'(lba), mon_e.lba);
                chk(int'(cur_cyl) == mon_e.cyl, "R6 cylinder", int'(cur_cyl), mon_e.cyl);
                chk(int'(cur_head) == mon_e.head, "R6 head", int'(cur_head), mon_e.head);
                chk(int'(cur_sec) == mon_e.sec, "R6 sector", int'(cur_sec), mon_e.sec);
            end
        end
    end

    task automatic send_byte(input logic [7:0] v);
        @(negedge clk);
        cmd_we   = 1'b1;
        cmd_data = v;
    endtask

    task automatic end_cmd();
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done seen", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chk(busy == 1'b0, "R9 idle after done", int'(busy), 0);
    endtask

    task automatic xfer(input int drv, input bit wr, input int cyl, input int head,
                        input int sec, input int cnt, input logic [7:0] ctrl,
                        input bit stall);
        int c, h, s, n;
        exp_t e;
        c = cyl; h = head; s = sec;
        for (int i = 0; i < cnt; i++) begin
            e.commit = wr;
            e.lba    = lba_of(c, h, s, heads_m[drv]);
            e.cyl    = c;
            e.head   = h;
            e.sec    = s;
            expq.push_back(e);
            s++;
            if (s >= SPT) begin
                s = 0;
                h++;
                if (h >= heads_m[drv]) begin
                    h = 0;
                    c++;
                end
            end
        end
        fc = c; fh = h; fs = s;
        dma_tb = (ctrl[1:0] != 2'b00);
        send_byte(wr ? 8'h0A : 8'h08);
        send_byte({2'b00, drv[0], head[4:0]});
        send_byte({cyl[9:8], sec[5:0]});
        send_byte(cyl[7:0]);
        send_byte(cnt[7:0]);
        send_byte(ctrl);
        end_cmd();
        if (stall) begin
            force_pio = 1'b1;
            repeat (40) @(negedge clk);
            chk(byte_idx == 9'd0, "R7 pio ignored in DMA mode", int'(byte_idx), 0);
            chk(dma_req == 1'b1, "R7 dma_req held", int'(dma_req), 1);
            send_byte(8'h0A);   // R12 byte while busy
            end_cmd();
            force_pio = 1'b0;
        end
        pump_en = 1'b1;
        wait_done(n);
        pump_en = 1'b0;
        if (cnt == 0) chk(n <= 3, "R9 zero count immediate", n, 3);
        chk(expq.size() == 0, wr ? "R5 all commits seen" : "R4 all starts seen",
            expq.size(), 0);
        chk(int'(cur_cyl) == fc && int'(cur_head) == fh && int'(cur_sec) == fs,
            "R6 final position", int'({cur_cyl, cur_head, cur_sec}), (fc << 11) | (fh << 6) | fs);
        chk(int'(cur_drive) == drv, "R2 drive select", int'(cur_drive), drv);
    endtask

    task automatic set_params(input int drv, input int cyls, input int hd, input int rwc,
                              input int wpc, input int ecc);
        int n;
        send_byte(8'h0C);
        send_byte({2'b00, drv[0], 5'd0});
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte({6'd0, cyls[9:8]});
        send_byte(cyls[7:0]);
        send_byte({3'd0, hd[4:0]});
        send_byte({6'd0, rwc[9:8]});
        send_byte(rwc[7:0]);
        send_byte({6'd0, wpc[9:8]});
        send_byte(wpc[7:0]);
        send_byte(ecc[7:0]);
        end_cmd();
        wait_done(n);
        heads_m[drv] = hd;
        chk(int'(geo_cyls) == cyls, "R8 cylinders", int'(geo_cyls), cyls);
        chk(int'(geo_heads) == hd, "R8 heads", int'(geo_heads), hd);
        chk(int'(geo_rwc) == rwc, "R8 reduced current", int'(geo_rwc), rwc);
        chk(int'(geo_wpc) == wpc, "R8 precomp", int'(geo_wpc), wpc);
        chk(int'(geo_ecc) == ecc, "R8 ecc length", int'(geo_ecc), ecc);
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        heads_m[0] = 4;
        heads_m[1] = 4;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 0 && done == 0, "R1 idle after reset", int'({busy, done}), 0);
        chk(dma_req == 0 && sec_start == 0 && sec_commit == 0, "R1 strobes low",
            int'({dma_req, sec_start, sec_commit}), 0);
        chk(geo_cyls == 10'd612, "R1 default cylinders", int'(geo_cyls), 612);
        chk(geo_heads == 5'd4, "R1 default heads", int'(geo_heads), 4);
        chk(geo_rwc == 10'd613 && geo_wpc == 10'd613, "R1 default rwc/wpc",
            int'(geo_rwc), 613);
        chk(geo_ecc == 8'd11, "R1 default ecc", int'(geo_ecc), 11);

        // R4 R6: PIO read crossing a track boundary
        xfer(0, 1'b0, 5, 1, 15, 4, 8'h00, 1'b0);

        // R5 R7 R6: DMA write crossing a cylinder boundary, split cylinder field
        xfer(0, 1'b1, 10'h2A3, 3, 16, 2, 8'h01, 1'b0);

        // R8 R10: load drive 1 geometry, then read using it
        set_params(1, 10'h155, 6, 10'h300, 10'h2FF, 7);
        xfer(1, 1'b0, 1, 5, 16, 2, 8'h00, 1'b0);

        // R10 R11 R9: zero-count command on drive 0 shows its defaults
        xfer(0, 1'b0, 7, 2, 3, 0, 8'hC5, 1'b0);
        chk(geo_heads == 5'd4 && geo_cyls == 10'd612, "R10 drive 0 geometry kept",
            int'(geo_heads), 4);
        chk(ctl_no_retry == 1'b1, "R11 retry disable", int'(ctl_no_retry), 1);
        chk(ctl_no_ecc_retry == 1'b1, "R11 ecc retry disable", int'(ctl_no_ecc_retry), 1);
        chk(ctl_step == 3'd5, "R11 step rate", int'(ctl_step), 5);

        // R7 R12: DMA read stalled with host strobes, byte sent while busy
        xfer(0, 1'b0, 2, 0, 0, 1, 8'h02, 1'b1);

        // R12: unknown opcode dropped, next command parses normally
        send_byte(8'h55);
        end_cmd();
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R12 unknown opcode ignored", int'(busy), 0);
        xfer(0, 1'b1, 9, 0, 4, 1, 8'h00, 1'b0);
        chk(ctl_no_retry == 1'b0 && ctl_step == 3'd0, "R11 control reloaded",
            int'(ctl_step), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule